// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Flags and Echo

This block turns an asynchronous serial line into words of 5 to 8 bits. It uses a 16x oversampling clock enable that comes from outside the block. The serial input first passes through a synchronizer. A frame decoder then checks that each start bit is real and samples each data bit in the middle of its bit time. It can also take a parity bit, and it checks the stop bit. The finished word goes into a single holding register. That register reports that it is full and carries an overrun flag, a framing-error flag and a parity-error flag.

A host reads the holding register with a one-cycle read strobe. The read empties the register and clears all of its flags. An optional interrupt output is high while a word is waiting. In echo mode the synchronized receive line is copied straight to the transmit output. When echo mode is off, the transmit output rests at the idle level.

Top module: `serial_rx_echo`

## Requirements
- R1: `word_len_i` selects the word length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data arrives LSB first. Bits above the word length read as 0 on `data_o`.
- R2: A start bit is accepted only if the line still samples low 8 ticks after the low level is first seen. A shorter low pulse produces no word.
- R3: `par_mode_i` selects parity handling. Code 0 means no parity bit. Code 1 means odd, code 2 means even, and in both cases `par_err_o` is set when the count of ones in the data bits plus the parity bit has the wrong sense. Code 3 means mark: the parity bit is consumed but never checked.
- R4: `frame_err_o` is set when the first stop bit samples 0. After such a frame the receiver waits for the line to return high before it looks for the next start bit.
- R5: When a word completes and the holding register is empty, the word is loaded into the register and `full_o` goes high.
- R6: When a word completes while `full_o` is high and no read is taking place, `overrun_o` is set. The stored word and its flags are kept.
- R7: A read strobe `rd_i` clears `full_o`, `overrun_o`, `frame_err_o` and `par_err_o`. None of the error flags is ever high while `full_o` is low.
- R8: `irq_o` is high exactly when `irq_en_i` is 1 and `full_o` is high.
- R9: With `echo_en_i` at 1, `txd_o` follows `rxd_i` two clocks later. With `echo_en_i` at 0, `txd_o` holds 1.
- R10: After reset `full_o`, all error flags and `irq_o` are 0, `data_o` is 0 and `txd_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | Oversampling enable, 16 per bit time |
| rxd_i | input | 1 | Serial receive line |
| word_len_i | input | 2 | Word length code |
| par_mode_i | input | 2 | Parity mode code |
| echo_en_i | input | 1 | Copy receive line to transmit output |
| irq_en_i | input | 1 | Receive interrupt enable |
| rd_i | input | 1 | Read strobe for the holding register |
| data_o | output | 8 | Received word |
| full_o | output | 1 | Holding register full |
| overrun_o | output | 1 | Word lost while register full |
| frame_err_o | output | 1 | Stop bit sampled low |
| par_err_o | output | 1 | Parity mismatch |
| irq_o | output | 1 | Receive interrupt |
| txd_o | output | 1 | Transmit line (echo) |

## Verification
The first stop bit is sampled in the middle of its bit time. `full_o`, `data_o` and the error flags change two clocks after that tick: one clock for the frame decoder's completion pulse and one for the holding register. The bench checks these outputs only after it has driven the whole stop bit, about half a bit time later, so the sampling point always falls after the update. A read takes effect at the next clock edge, and the bench samples one full clock after the strobe. The echo path is two clocks deep, and the bench compares `txd_o` with the driven level in the middle of each bit.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAIT_HI
  } rx_state_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_ODD  = 2'd1,
    PAR_EVEN = 2'd2,
    PAR_MARK = 2'd3
  } par_mode_e;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic [1:0]        word_len_i,
  input  logic [1:0]        par_mode_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              fe_o,
  output logic              pe_o
);

  localparam int unsigned CNT_W    = $clog2(OVS);
  localparam int unsigned IDX_W    = $clog2(DATA_W);
  localparam int unsigned MIN_BITS = DATA_W - 3;
  localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] FULL_M1 = CNT_W'(OVS - 1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  last_idx;
  logic [DATA_W-1:0] shreg_q;
  logic              par_bit_q;
  logic              ones;
  logic              par_bad;

  assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(word_len_i);
  assign ones     = (^shreg_q) ^ par_bit_q;

  always_comb begin
    unique case (par_mode_e'(par_mode_i))
      PAR_ODD:  par_bad = ~ones;
      PAR_EVEN: par_bad = ones;
      default:  par_bad = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      shreg_q   <= '0;
      par_bit_q <= 1'b0;
      done_o    <= 1'b0;
      data_o    <= '0;
      fe_o      <= 1'b0;
      pe_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            if (!rx_i) begin
              state_q <= ST_START;
              cnt_q   <= '0;
            end
          end
          ST_START: begin
            if (cnt_q == HALF_M1) begin
              cnt_q <= '0;
              if (!rx_i) begin
                state_q   <= ST_DATA;
                idx_q     <= '0;
                shreg_q   <= '0;
                par_bit_q <= 1'b0;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt_q == FULL_M1) begin
              cnt_q          <= '0;
              shreg_q[idx_q] <= rx_i;
              if (idx_q == last_idx) begin
                state_q <= (par_mode_e'(par_mode_i) == PAR_NONE) ? ST_STOP : ST_PAR;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (cnt_q == FULL_M1) begin
              cnt_q     <= '0;
              par_bit_q <= rx_i;
              state_q   <= ST_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt_q == FULL_M1) begin
              cnt_q   <= '0;
              done_o  <= 1'b1;
              data_o  <= shreg_q;
              fe_o    <= ~rx_i;
              pe_o    <= par_bad;
              state_q <= rx_i ? ST_IDLE : ST_WAIT_HI;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_WAIT_HI: begin
            if (rx_i) state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              fe_i,
  input  logic              pe_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              fe_o,
  output logic              pe_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
      ovr_o  <= 1'b0;
      fe_o   <= 1'b0;
      pe_o   <= 1'b0;
    end else begin
      if (rd_i) begin
        full_o <= 1'b0;
        ovr_o  <= 1'b0;
        fe_o   <= 1'b0;
        pe_o   <= 1'b0;
      end
      if (done_i) begin
        // read in the same cycle frees the register for the new word
        if (full_o && !rd_i) begin
          ovr_o <= 1'b1;
        end else begin
          data_o <= data_i;
          full_o <= 1'b1;
          fe_o   <= fe_i;
          pe_o   <= pe_i;
        end
      end
    end
  end

endmodule

// File: rtl/serial_rx_echo.sv
module serial_rx_echo #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned OVS       = 16,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic              rxd_i,
  input  logic [1:0]        word_len_i,
  input  logic [1:0]        par_mode_i,
  input  logic              echo_en_i,
  input  logic              irq_en_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              overrun_o,
  output logic              frame_err_o,
  output logic              par_err_o,
  output logic              irq_o,
  output logic              txd_o
);

  logic              rx_s;
  logic              word_done;
  logic [DATA_W-1:0] word_data;
  logic              word_fe;
  logic              word_pe;

  rx_line_sync #(.STAGES(SYNC_STGS)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  rx_frame_fsm #(.DATA_W(DATA_W), .OVS(OVS)) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick16_i),
    .rx_i      (rx_s),
    .word_len_i(word_len_i),
    .par_mode_i(par_mode_i),
    .done_o    (word_done),
    .data_o    (word_data),
    .fe_o      (word_fe),
    .pe_o      (word_pe)
  );

  rx_hold_reg #(.DATA_W(DATA_W)) i_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_i(word_done),
    .data_i(word_data),
    .fe_i  (word_fe),
    .pe_i  (word_pe),
    .rd_i  (rd_i),
    .data_o(data_o),
    .full_o(full_o),
    .ovr_o (overrun_o),
    .fe_o  (frame_err_o),
    .pe_o  (par_err_o)
  );

  assign irq_o = irq_en_i & full_o;
  assign txd_o = echo_en_i ? rx_s : 1'b1;

endmodule

// File: rtl/serial_rx_echo_chk.sv
module serial_rx_echo_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rxd_i,
  input logic              echo_en_i,
  input logic              irq_en_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] data_o,
  input logic              full_o,
  input logic              overrun_o,
  input logic              frame_err_o,
  input logic              par_err_o,
  input logic              irq_o,
  input logic              txd_o,
  input logic              word_done
);

  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 1'b1;
  end

  p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done && (!full_o || rd_i) |=> full_o);

  p_ovr_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done && full_o && !rd_i |=> overrun_o && full_o && $stable(data_o));

  p_rd_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !word_done |=> !full_o && !overrun_o && !frame_err_o && !par_err_o);

  p_flags_need_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o || frame_err_o || par_err_o) |-> full_o);

  p_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> full_o && irq_en_i);

  p_echo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    echo_en_i && age_q >= 2'd2 |-> txd_o == $past(rxd_i, 2));

endmodule

bind serial_rx_echo serial_rx_echo_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rxd_i      (rxd_i),
  .echo_en_i  (echo_en_i),
  .irq_en_i   (irq_en_i),
  .rd_i       (rd_i),
  .data_o     (data_o),
  .full_o     (full_o),
  .overrun_o  (overrun_o),
  .frame_err_o(frame_err_o),
  .par_err_o  (par_err_o),
  .irq_o      (irq_o),
  .txd_o      (txd_o),
  .word_done  (word_done)
);

// File: tb/test_serial_rx_echo.sv
module test_serial_rx_echo;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick16_i = 1'b0;
  logic       rxd_i = 1'b1;
  logic [1:0] word_len_i = 2'd3;
  logic [1:0] par_mode_i = 2'd0;
  logic       echo_en_i = 1'b0;
  logic       irq_en_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] data_o;
  logic       full_o, overrun_o, frame_err_o, par_err_o, irq_o, txd_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  serial_rx_echo i_serial_rx_echo (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick16_i(tick16_i), .rxd_i(rxd_i),
    .word_len_i(word_len_i), .par_mode_i(par_mode_i), .echo_en_i(echo_en_i),
    .irq_en_i(irq_en_i), .rd_i(rd_i), .data_o(data_o), .full_o(full_o),
    .overrun_o(overrun_o), .frame_err_o(frame_err_o), .par_err_o(par_err_o),
    .irq_o(irq_o), .txd_o(txd_o)
  );

  always #10 clk_i = ~clk_i;

  // 16x enable: one clock in four, so one bit time is 64 clocks
  initial begin
    int tc = 0;
    forever begin
      @(negedge clk_i);
      tick16_i = (tc == 3);
      tc = (tc + 1) % 4;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_word(input logic [7:0] d, input int nbits);
    return d & 8'((1 << nbits) - 1);
  endfunction

  function automatic logic exp_pe(input logic [1:0] pm, input logic bad_par);
    return (pm == 2'd1 || pm == 2'd2) && bad_par;
  endfunction

  task automatic drive_bit(input logic v, input bit echo_chk);
    rxd_i = v;
    repeat (32) @(negedge clk_i);
    if (echo_chk) chk("R9 echo", txd_o, echo_en_i ? v : 1'b1);
    repeat (32) @(negedge clk_i);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic bad_par,
                            input logic bad_stop, input bit echo_chk);
    int nbits = 5 + int'(word_len_i);
    logic ones = ^exp_word(d, nbits);
    logic pbit;
    case (par_mode_i)
      2'd1:    pbit = ~ones;
      2'd2:    pbit = ones;
      default: pbit = 1'b1;
    endcase
    drive_bit(1'b0, echo_chk);
    for (int i = 0; i < nbits; i++) drive_bit(d[i], echo_chk);
    if (par_mode_i != 2'd0) drive_bit(pbit ^ bad_par, echo_chk);
    drive_bit(~bad_stop, echo_chk);
    rxd_i = 1'b1;
    repeat (8) @(negedge clk_i);
  endtask

  task automatic do_read();
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic chk_empty(input string tag);
    chk({tag, " full"}, full_o, 1'b0);
    chk({tag, " ovr"}, overrun_o, 1'b0);
    chk({tag, " fe"}, frame_err_o, 1'b0);
    chk({tag, " pe"}, par_err_o, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk_i);
    // R10 reset state
    chk("R10 full", full_o, 1'b0);
    chk("R10 data", data_o, 8'h00);
    chk("R10 irq", irq_o, 1'b0);
    chk("R10 txd", txd_o, 1'b1);
    chk_empty("R10");
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // R5 R8: 8-bit word, no parity, interrupt enabled
    irq_en_i = 1'b1;
    send_frame(8'hA5, 1'b0, 1'b0, 1'b1);
    chk("R5 data", data_o, 8'hA5);
    chk("R5 full", full_o, 1'b1);
    chk("R8 irq on", irq_o, 1'b1);
    chk("R3 none pe", par_err_o, 1'b0);
    do_read();
    chk_empty("R7 read");
    chk("R8 irq off", irq_o, 1'b0);

    // R1: 5-bit word from all-ones data byte, high bits read 0
    word_len_i = 2'd0;
    send_frame(8'hFF, 1'b0, 1'b0, 1'b0);
    chk("R1 5bit", data_o, 8'h1F);
    do_read();
    word_len_i = 2'd2;
    send_frame(8'hD6, 1'b0, 1'b0, 1'b0);
    chk("R1 7bit", data_o, 8'h56);
    do_read();

    // R3: parity modes
    word_len_i = 2'd3;
    par_mode_i = 2'd2;
    send_frame(8'h37, 1'b0, 1'b0, 1'b0);
    chk("R3 even ok", par_err_o, 1'b0);
    do_read();
    send_frame(8'h37, 1'b1, 1'b0, 1'b0);
    chk("R3 even bad", par_err_o, 1'b1);
    chk("R3 even data", data_o, 8'h37);
    do_read();
    par_mode_i = 2'd1;
    send_frame(8'h81, 1'b0, 1'b0, 1'b0);
    chk("R3 odd ok", par_err_o, 1'b0);
    do_read();
    send_frame(8'h81, 1'b1, 1'b0, 1'b0);
    chk("R3 odd bad", par_err_o, 1'b1);
    do_read();
    par_mode_i = 2'd3;
    send_frame(8'h3C, 1'b1, 1'b0, 1'b0);
    chk("R3 mark ignored", par_err_o, 1'b0);
    chk("R3 mark data", data_o, 8'h3C);
    do_read();
    par_mode_i = 2'd0;

    // R4: framing error, then a clean word is still received
    send_frame(8'h5A, 1'b0, 1'b1, 1'b0);
    chk("R4 fe", frame_err_o, 1'b1);
    chk("R4 full", full_o, 1'b1);
    do_read();
    chk_empty("R7 fe clear");
    send_frame(8'hC3, 1'b0, 1'b0, 1'b0);
    chk("R4 recover data", data_o, 8'hC3);
    chk("R4 recover fe", frame_err_o, 1'b0);
    do_read();

    // R6: overrun keeps the first word
    send_frame(8'h11, 1'b0, 1'b0, 1'b0);
    send_frame(8'h22, 1'b0, 1'b1, 1'b0);
    chk("R6 ovr", overrun_o, 1'b1);
    chk("R6 keep data", data_o, 8'h11);
    chk("R6 keep fe", frame_err_o, 1'b0);
    do_read();
    chk_empty("R7 ovr clear");

    // R8: interrupt disabled while full
    irq_en_i = 1'b0;
    send_frame(8'h66, 1'b0, 1'b0, 1'b0);
    chk("R8 irq masked", irq_o, 1'b0);
    chk("R8 full", full_o, 1'b1);
    do_read();

    // R2: short low pulse (3 ticks) is not a start bit
    rxd_i = 1'b0;
    repeat (12) @(negedge clk_i);
    rxd_i = 1'b1;
    repeat (800) @(negedge clk_i);
    chk("R2 glitch full", full_o, 1'b0);

    // R9: echo on and off
    echo_en_i = 1'b1;
    send_frame(8'h9B, 1'b0, 1'b0, 1'b1);
    do_read();
    echo_en_i = 1'b0;
    send_frame(8'h4E, 1'b0, 1'b0, 1'b1);
    chk("R9 off data", data_o, 8'h4E);
    do_read();

    // random frames
    for (int n = 0; n < 24; n++) begin
      logic [7:0] d = 8'($urandom);
      logic bp = ($urandom % 6) == 0;
      logic bs = ($urandom % 6) == 0;
      word_len_i = 2'($urandom);
      par_mode_i = 2'($urandom);
      irq_en_i   = 1'($urandom);
      send_frame(d, bp, bs, 1'b0);
      chk("R1 rnd data", data_o, exp_word(d, 5 + int'(word_len_i)));
      chk("R5 rnd full", full_o, 1'b1);
      chk("R3 rnd pe", par_err_o, exp_pe(par_mode_i, bp));
      chk("R4 rnd fe", frame_err_o, bs);
      chk("R8 rnd irq", irq_o, irq_en_i);
      do_read();
      chk_empty("R7 rnd");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule